// File: doc/BRIEF.md
# Programmable CAS-Latency Read Return Pipeline

This block models when read data comes back on a synchronous DRAM data path. Each clock a read strobe and a column tag may enter. The tag is carried through a short shift pipeline. It reappears on the data-valid output after the programmed column latency, which is two or three clocks. The output-enable line rises one clock earlier, so the data drivers are on before the data is valid.

A 12-bit mode word can be loaded at any clock. The block decodes it into the column latency, the burst length, the burst ordering and the write-burst policy. It holds these values until the next accepted load. A load is refused, and an error pulse is raised, in three cases: the word carries a reserved code, the operating-mode field is not zero, or the banks are reported busy. A refused load leaves the previous settings unchanged.

Top module: `cas_read_pipe`

## Requirements
- R1: After reset the settings are latency 3, burst length 1 (not full page), sequential ordering and writes following the burst length. `mode_err`, `out_en` and `dat_vld` are low and `dat_tag` is zero.
- R2: An accepted load takes effect from the clock after the load edge. Latency field bits 6:4 equal to 010 give `cas_lat`=2, and 011 gives `cas_lat`=3.
- R3: Burst field bits 2:0 decode as follows: 000 gives 1, 001 gives 2, 010 gives 4 and 011 gives 8, each with `burst_full`=0. 111 gives `burst_full`=1 with `burst_len`=0.
- R4: Bit 3 set gives `burst_ilv`=1 (interleaved order). Bit 9 set gives `wr_single`=1 (writes are single-location).
- R5: A load is rejected when any of these holds: the latency field is not 010 or 011, bits 8:7 are nonzero, bits 11:10 are nonzero, the burst field is 100, 101 or 110, or the burst field is 111 with bit 3 set. On the clock after a rejected load, `mode_err` is high and all settings are unchanged. After an accepted load or a clock with no load, `mode_err` is low.
- R6: A load while `banks_idle` is low is rejected in the same way, even if the word is legal.
- R7: A read sampled at edge n with latency m gives `dat_vld`=1 with `dat_tag` equal to that read's tag after edge n+m. When no read is due, `dat_vld` is 0 and `dat_tag` is 0.
- R8: `out_en` is high after edge n+m-1 and after edge n+m for each such read, and it is low when no read is within that window.
- R9: Reads issued on consecutive clocks return on consecutive clocks, in issue order, each with its own tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read command strobe |
| rd_tag | input | TAG_W | Column tag carried with the read |
| mode_wr | input | 1 | Mode word load strobe |
| mode_word | input | 12 | Mode word |
| banks_idle | input | 1 | High when every bank is precharged |
| out_en | output | 1 | Data driver enable |
| dat_vld | output | 1 | Returned data valid |
| dat_tag | output | TAG_W | Tag of the returned read |
| cas_lat | output | 2 | Active column latency (2 or 3) |
| burst_len | output | 4 | Burst length (1, 2, 4, 8; 0 for full page) |
| burst_full | output | 1 | Full-page burst selected |
| burst_ilv | output | 1 | Interleaved burst order |
| wr_single | output | 1 | Writes are single-location |
| mode_err | output | 1 | Pulse: previous clock's load was rejected |

## Verification
A wrong settings register shows on the decoded outputs one clock after the load that corrupted it. A load that should have been refused shows as changed fields together with a missing error pulse, also one clock later. A pipeline fault shows two or three clocks after the affected read: a valid strobe in the wrong cycle, a returned tag out of order, or an enable edge that fails to lead the valid edge by one clock. The sweep loads all 4096 mode words, with the busy flag mixed in. Long random and back-to-back read streams are then run at both latencies, and the outputs are compared each cycle.

// File: rtl/cas_pkg.sv
package cas_pkg;
  localparam int MODE_W = 12;

  typedef struct packed {
    logic       lat3;       // 1: three-cycle latency, 0: two-cycle
    logic [3:0] blen;       // 1,2,4,8 or 0 for full page
    logic       bfull;
    logic       interleave;
    logic       wr_single;
  } mode_cfg_t;

  localparam mode_cfg_t CFG_RESET = '{lat3: 1'b1, blen: 4'd1, bfull: 1'b0,
                                      interleave: 1'b0, wr_single: 1'b0};

  function automatic logic word_legal(input logic [MODE_W-1:0] w);
    logic lat_ok, op_ok, rsv_ok, bl_ok;
    lat_ok = (w[6:4] == 3'b010) || (w[6:4] == 3'b011);
    op_ok  = (w[8:7] == 2'b00);
    rsv_ok = (w[11:10] == 2'b00);
    bl_ok  = (w[2] == 1'b0) || ((w[2:0] == 3'b111) && !w[3]);
    return lat_ok && op_ok && rsv_ok && bl_ok;
  endfunction

  function automatic mode_cfg_t word_decode(input logic [MODE_W-1:0] w);
    mode_cfg_t c;
    c.lat3       = w[4];
    c.bfull      = (w[2:0] == 3'b111);
    c.blen       = c.bfull ? 4'd0 : (4'd1 << w[1:0]);
    c.interleave = w[3];
    c.wr_single  = w[9];
    return c;
  endfunction
endpackage

// File: rtl/cas_mode_reg.sv
module cas_mode_reg
  import cas_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [MODE_W-1:0] word,
  input  logic              banks_idle,
  output mode_cfg_t         cfg,
  output logic              err
);
  logic word_ok;
  logic accept;
  logic reject;

  assign word_ok = word_legal(word);
  assign accept  = wr && word_ok && banks_idle;
  assign reject  = wr && !accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= CFG_RESET;
      err <= 1'b0;
    end else begin
      if (accept) cfg <= word_decode(word);
      err <= reject;
    end
  end

  p_keep_on_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $stable(cfg));
  p_busy_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !banks_idle) |=> err);
  p_lat_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !err && word[6:4] == 3'b010 && banks_idle && word_ok) |=> !cfg.lat3);
endmodule

// File: rtl/cas_lat_pipe.sv
module cas_lat_pipe #(
  parameter int TAG_W   = 9,
  parameter int MAX_LAT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [TAG_W-1:0] tag,
  input  logic             lat3,
  output logic             oe,
  output logic             vld,
  output logic [TAG_W-1:0] vtag
);
  localparam int DEPTH = MAX_LAT + 1;
  localparam int IW    = $clog2(DEPTH);

  logic [DEPTH-1:0] v;
  logic [TAG_W-1:0] t [DEPTH];
  logic [IW-1:0]    m_idx;
  logic [IW-1:0]    pre_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v <= '0;
      for (int k = 0; k < DEPTH; k++) t[k] <= '0;
    end else begin
      v[0] <= req;
      t[0] <= req ? tag : '0;
      for (int k = 1; k < DEPTH; k++) begin
        v[k] <= v[k-1];
        t[k] <= t[k-1];
      end
    end
  end

  assign m_idx   = lat3 ? IW'(3) : IW'(2);
  assign pre_idx = m_idx - IW'(1);
  assign vld     = v[m_idx];
  assign oe      = v[m_idx] | v[pre_idx];
  assign vtag    = v[m_idx] ? t[m_idx] : '0;

  p_oe_leads_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vld) && $stable(lat3)) |-> $past(oe));
  p_ret_lat2_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !lat3) |-> $past(req, 3));
  p_ret_lat3_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && lat3) |-> $past(req, 4));
  p_tag_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !lat3) |-> (vtag == $past(tag, 3)));
endmodule

// File: rtl/cas_read_pipe.sv
module cas_read_pipe
  import cas_pkg::*;
#(
  parameter int TAG_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              banks_idle,
  output logic              out_en,
  output logic              dat_vld,
  output logic [TAG_W-1:0]  dat_tag,
  output logic [1:0]        cas_lat,
  output logic [3:0]        burst_len,
  output logic              burst_full,
  output logic              burst_ilv,
  output logic              wr_single,
  output logic              mode_err
);
  mode_cfg_t cfg;

  cas_mode_reg u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (mode_wr),
    .word       (mode_word),
    .banks_idle (banks_idle),
    .cfg        (cfg),
    .err        (mode_err)
  );

  cas_lat_pipe #(.TAG_W(TAG_W), .MAX_LAT(3)) u_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (rd_req),
    .tag   (rd_tag),
    .lat3  (cfg.lat3),
    .oe    (out_en),
    .vld   (dat_vld),
    .vtag  (dat_tag)
  );

  assign cas_lat    = cfg.lat3 ? 2'd3 : 2'd2;
  assign burst_len  = cfg.blen;
  assign burst_full = cfg.bfull;
  assign burst_ilv  = cfg.interleave;
  assign wr_single  = cfg.wr_single;

  p_full_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    burst_full |-> (burst_len == 4'd0 && !burst_ilv));
endmodule

// File: tb/tb_cas_read_pipe.sv
module tb_cas_read_pipe;
  localparam int TW = 9;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, rd_req, mode_wr, banks_idle;
  logic [TW-1:0] rd_tag;
  logic [11:0] mode_word;
  logic out_en, dat_vld, burst_full, burst_ilv, wr_single, mode_err;
  logic [TW-1:0] dat_tag;
  logic [1:0] cas_lat;
  logic [3:0] burst_len;

  cas_read_pipe #(.TAG_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_tag(rd_tag),
    .mode_wr(mode_wr), .mode_word(mode_word), .banks_idle(banks_idle),
    .out_en(out_en), .dat_vld(dat_vld), .dat_tag(dat_tag),
    .cas_lat(cas_lat), .burst_len(burst_len), .burst_full(burst_full),
    .burst_ilv(burst_ilv), .wr_single(wr_single), .mode_err(mode_err)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  bit req_h [16384];
  logic [TW-1:0] tag_h [16384];
  // expected settings
  int e_lat = 3, e_bl = 1;
  bit e_full = 0, e_ilv = 0, e_ws = 0;
  logic [15:0] lf = 16'hACE1;

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  task automatic step();
    req_h[cyc+1] = rd_req;
    tag_h[cyc+1] = rd_tag;
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  function automatic logic [8:0] dut_cfg();
    return {cas_lat, burst_len, burst_full, burst_ilv, wr_single};
  endfunction

  function automatic logic [8:0] exp_cfg();
    return {2'(e_lat), 4'(e_bl), e_full, e_ilv, e_ws};
  endfunction

  task automatic check_stream(string rq);
    bit ev, eo;
    logic [TW-1:0] et;
    ev = req_h[cyc - e_lat];
    eo = ev | req_h[cyc - e_lat + 1];
    et = ev ? tag_h[cyc - e_lat] : '0;
    chk({out_en, dat_vld, dat_tag} == {eo, ev, et}, rq,
        {out_en, dat_vld, dat_tag}, {eo, ev, et});
  endtask

  task automatic run_stream(int lat);
    mode_wr = 1; banks_idle = 1;
    mode_word = (lat == 2) ? 12'h020 : 12'h030;
    step();
    mode_wr = 0;
    e_lat = lat; e_bl = 1; e_full = 0; e_ilv = 0; e_ws = 0;
    chk(dut_cfg() == exp_cfg() && !mode_err, "R2", dut_cfg(), exp_cfg());
    repeat (6) step();
    for (int i = 0; i < 260; i++) begin
      if (i >= 100 && i < 140) rd_req = 1;      // back-to-back run
      else rd_req = lf[0] ^ lf[5];
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      rd_tag = TW'(i * 7 + lat);
      step();
      if (i >= 100 && i < 145) check_stream("R9 back-to-back");
      else check_stream("R7 R8 return timing");
    end
    rd_req = 0;
    for (int i = 0; i < 6; i++) begin
      step();
      check_stream("R8 drain");
    end
  endtask

  initial begin
    rst_n = 0; rd_req = 0; rd_tag = '0; mode_wr = 0; mode_word = '0; banks_idle = 1;
    repeat (3) step();
    rst_n = 1;
    // R1: reset state
    chk(dut_cfg() == exp_cfg(), "R1 settings", dut_cfg(), exp_cfg());
    chk({mode_err, out_en, dat_vld, dat_tag} == '0, "R1 outputs",
        {mode_err, out_en, dat_vld, dat_tag}, 0);
    step();
    chk(dut_cfg() == exp_cfg() && !mode_err, "R1 hold", dut_cfg(), exp_cfg());

    // full sweep of mode words, busy flag mixed in
    for (int w = 0; w < 4096; w++) begin
      bit legal, idle, e_err;
      logic [11:0] ww;
      ww = 12'(w);
      idle = (w % 5) != 2;
      legal = (ww[6:4] == 3'd2 || ww[6:4] == 3'd3) && ww[8:7] == 0 && ww[11:10] == 0
              && (ww[2:0] < 3'd4 || (ww[2:0] == 3'd7 && !ww[3]));
      e_err = !(legal && idle);
      mode_wr = 1; mode_word = ww; banks_idle = idle;
      step();
      if (!e_err) begin
        e_lat = ww[6:4] == 3'd2 ? 2 : 3;
        e_full = ww[2:0] == 3'd7;
        e_bl = e_full ? 0 : (ww[1:0] == 0 ? 1 : ww[1:0] == 1 ? 2 : ww[1:0] == 2 ? 4 : 8);
        e_ilv = ww[3];
        e_ws = ww[9];
      end
      if (!e_err)
        chk(dut_cfg() == exp_cfg() && !mode_err, "R2 R3 R4 accepted load",
            {mode_err, dut_cfg()}, {1'b0, exp_cfg()});
      else if (legal)
        chk(dut_cfg() == exp_cfg() && mode_err, "R6 busy reject",
            {mode_err, dut_cfg()}, {1'b1, exp_cfg()});
      else
        chk(dut_cfg() == exp_cfg() && mode_err, "R5 illegal reject",
            {mode_err, dut_cfg()}, {1'b1, exp_cfg()});
    end
    mode_wr = 0; banks_idle = 1;
    step();
    chk(!mode_err && dut_cfg() == exp_cfg(), "R5 no load clears flag",
        {mode_err, dut_cfg()}, {1'b0, exp_cfg()});

    run_stream(2);
    run_stream(3);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule